// File: doc/BRIEF.md
# Remote Read Bus Arbiter

This block shares a local data-memory bus between an on-chip processor and a processor outside the chip. While no remote read is pending, the processor's timing unit raises a bus request and the block grants it at once. When the remote side asserts both its enable and its read strobe, the block lowers its acknowledge to hold off the remote side. It then takes the bus at the first clock edge with no local request pending, and grants nothing locally until the remote read has finished.

A remote read runs through a fixed series of states. First comes a setup cycle, in which the block locks the bus and tri-states the address lines. Next comes a target cycle that picks the source of the read data: the interface register, the low or high byte of the program counter, or data memory. A data-memory read holds its read strobe for a number of wait cycles loaded at setup. Last comes a termination phase that holds the acknowledge high until the remote side drops its read strobe, which stretches the read. Two sticky status flags record finished remote reads and remote writes. Software clears each flag by writing a one to it.

Top module: `remote_read_arbiter`

## Requirements
- R1: After reset and while idle, lock_o, mem_rd, rd_flag and wr_flag are low, abus_oe and adbus_oe are high, rd_src is 0, and loc_gnt follows loc_req in the same cycle.
- R2: While idle, xack is low in the same cycle whenever rem_en and rem_rd are both high, even if loc_req is also high. With rem_en low, xack stays high.
- R3: While lockout is high, the block stays idle even with a remote read requested: lock_o stays low and local grants continue.
- R4: The block leaves idle at the first clock edge where rem_en, rem_rd and !loc_req are all true and lockout is low.
- R5: loc_gnt is low in every cycle outside idle, whatever loc_req does.
- R6: In the setup cycle, lock_o and xack are high and abus_oe is low. adbus_oe is low exactly when the request targets data memory (cmd_sel low and mem_sel[1] low).
- R7: In the cycle after setup, rd_src shows the target: 0 for the interface register (cmd_sel high), 1 for the program counter low byte (mem_sel 10), 2 for the high byte (mem_sel 11) and 3 for data memory. A non-memory target lasts one cycle, with adbus_oe high and mem_rd low.
- R8: A data-memory read holds mem_rd high with abus_oe and adbus_oe low for exactly dwait_cfg+1 cycles. A value of 0 means no wait state.
- R9: mem_sel 01 with cmd_sel low is handled exactly like mem_sel 00.
- R10: In the termination phase, lock_o is low and xack is high. The phase lasts while rem_rd stays high, and the block is idle at the edge after rem_rd is seen low.
- R11: rd_flag goes high in the first termination cycle and stays high until a cycle with clr_rd_flag high. If a set and a clear arrive in the same cycle, the set wins.
- R12: wr_flag goes high the cycle after wr_done, stays high until clr_wr_flag, and does not respond to clr_rd_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rem_en | input | 1 | Remote access enable |
| rem_rd | input | 1 | Remote read strobe |
| cmd_sel | input | 1 | High selects the interface register |
| mem_sel | input | 2 | Memory select: 00/01 data memory, 10 PC low, 11 PC high |
| lockout | input | 1 | Holds off remote reads while high |
| loc_req | input | 1 | Local bus request from the timing unit |
| dwait_cfg | input | DW_BITS | Data-memory wait cycles |
| wr_done | input | 1 | Remote write reached termination (stub) |
| clr_rd_flag | input | 1 | Write-one-to-clear for rd_flag |
| clr_wr_flag | input | 1 | Write-one-to-clear for wr_flag |
| loc_gnt | output | 1 | Local bus grant |
| xack | output | 1 | Remote acknowledge; low means wait |
| lock_o | output | 1 | Bus locked to the remote side |
| mem_rd | output | 1 | Data-memory read strobe |
| abus_oe | output | 1 | Address bus drive enable (low = tri-state) |
| adbus_oe | output | 1 | Address/data bus drive enable (low = tri-state) |
| rd_src | output | 2 | Read data source code |
| rd_flag | output | 1 | Sticky remote-read-done flag |
| wr_flag | output | 1 | Sticky remote-write-done flag |

## Verification
The read path is run with every combination of command bit, memory select and wait count, and with zero, one and two cycles of strobe hold after termination. Together these separate the four data sources, show that 01 takes the memory path, and confirm both the wait length and the strobe stretch. A local request is raised throughout each transaction to show that grants stop outside idle and resume on the return to idle. Further runs hold a remote read against lockout, against a pending local request and with enable low, and stress the two flags with clears that coincide with sets.

// File: rtl/rra_pkg.sv
package rra_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_RIC   = 3'd2,
        ST_PCL   = 3'd3,
        ST_PCH   = 3'd4,
        ST_DMEM  = 3'd5,
        ST_TERM  = 3'd6
    } rra_state_e;

    typedef enum logic [1:0] {
        SRC_IFREG = 2'd0,
        SRC_PCLO  = 2'd1,
        SRC_PCHI  = 2'd2,
        SRC_DMEM  = 2'd3
    } rra_src_e;

    typedef struct packed {
        rra_state_e st;
    } rra_regs_t;

    localparam int NUM_FLAGS = 2;
    localparam int FLAG_RD   = 0;
    localparam int FLAG_WR   = 1;

    // data memory is selected when the command bit is low and mem_sel is 0x
    function automatic logic is_dmem_target(input logic cmd, input logic [1:0] ms);
        return !cmd && !ms[1];
    endfunction

endpackage

// File: rtl/rra_wait_cnt.sv
module rra_wait_cnt #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/rra_sticky_flags.sv
module rra_sticky_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    logic [N-1:0] flag_d, flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        // a set in the same cycle as a clear takes priority
        always_comb begin
            flag_d[i] = flag_q[i];
            if (clr[i]) flag_d[i] = 1'b0;
            if (set[i]) flag_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign q = flag_q;
endmodule

// File: rtl/rra_out_dec.sv
module rra_out_dec
    import rra_pkg::*;
(
    input  rra_state_e  st,
    input  logic        req,
    input  logic        loc_req,
    input  logic        cmd_sel,
    input  logic [1:0]  mem_sel,
    output logic        loc_gnt,
    output logic        xack,
    output logic        lock_o,
    output logic        mem_rd,
    output logic        abus_oe,
    output logic        adbus_oe,
    output logic [1:0]  rd_src
);
    always_comb begin
        loc_gnt  = 1'b0;
        xack     = 1'b0;
        lock_o   = 1'b0;
        mem_rd   = 1'b0;
        abus_oe  = 1'b1;
        adbus_oe = 1'b1;
        rd_src   = SRC_IFREG;
        unique case (st)
            ST_IDLE: begin
                loc_gnt = loc_req;
                xack    = !req;
            end
            ST_SETUP: begin
                lock_o   = 1'b1;
                xack     = 1'b1;
                abus_oe  = 1'b0;
                adbus_oe = !is_dmem_target(cmd_sel, mem_sel);
            end
            ST_RIC: begin
                lock_o  = 1'b1;
                xack    = 1'b1;
                abus_oe = 1'b0;
                rd_src  = SRC_IFREG;
            end
            ST_PCL: begin
                lock_o  = 1'b1;
                xack    = 1'b1;
                abus_oe = 1'b0;
                rd_src  = SRC_PCLO;
            end
            ST_PCH: begin
                lock_o  = 1'b1;
                xack    = 1'b1;
                abus_oe = 1'b0;
                rd_src  = SRC_PCHI;
            end
            ST_DMEM: begin
                lock_o   = 1'b1;
                xack     = 1'b1;
                mem_rd   = 1'b1;
                abus_oe  = 1'b0;
                adbus_oe = 1'b0;
                rd_src   = SRC_DMEM;
            end
            ST_TERM: begin
                xack = 1'b1;
            end
            default: begin
                xack = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/remote_read_arbiter.sv
module remote_read_arbiter
    import rra_pkg::*;
#(
    parameter int DW_BITS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rem_en,
    input  logic               rem_rd,
    input  logic               cmd_sel,
    input  logic [1:0]         mem_sel,
    input  logic               lockout,
    input  logic               loc_req,
    input  logic [DW_BITS-1:0] dwait_cfg,
    input  logic               wr_done,
    input  logic               clr_rd_flag,
    input  logic               clr_wr_flag,
    output logic               loc_gnt,
    output logic               xack,
    output logic               lock_o,
    output logic               mem_rd,
    output logic               abus_oe,
    output logic               adbus_oe,
    output logic [1:0]         rd_src,
    output logic               rd_flag,
    output logic               wr_flag
);
    rra_regs_t r_d, r_q;
    logic req;
    logic cnt_load_d, cnt_dec_d, wait_zero;
    logic term_entry_d;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;

    assign req = rem_en && rem_rd;

    always_comb begin
        r_d        = r_q;
        cnt_load_d = 1'b0;
        cnt_dec_d  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req && !lockout && !loc_req) r_d.st = ST_SETUP;
            end
            ST_SETUP: begin
                cnt_load_d = 1'b1;
                if (cmd_sel) begin
                    r_d.st = ST_RIC;
                end else begin
                    unique case (mem_sel)
                        2'b10:   r_d.st = ST_PCL;
                        2'b11:   r_d.st = ST_PCH;
                        default: r_d.st = ST_DMEM;
                    endcase
                end
            end
            ST_RIC, ST_PCL, ST_PCH: begin
                r_d.st = ST_TERM;
            end
            ST_DMEM: begin
                if (wait_zero) r_d.st = ST_TERM;
                else           cnt_dec_d = 1'b1;
            end
            ST_TERM: begin
                if (!rem_rd) r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
        term_entry_d = (r_d.st == ST_TERM) && (r_q.st != ST_TERM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE};
        else        r_q <= r_d;
    end

    rra_wait_cnt #(.W(DW_BITS)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load_d),
        .load_val (dwait_cfg),
        .dec      (cnt_dec_d),
        .zero     (wait_zero)
    );

    assign flag_set[FLAG_RD] = term_entry_d;
    assign flag_set[FLAG_WR] = wr_done;
    assign flag_clr[FLAG_RD] = clr_rd_flag;
    assign flag_clr[FLAG_WR] = clr_wr_flag;

    rra_sticky_flags #(.N(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .q     (flag_q)
    );

    assign rd_flag = flag_q[FLAG_RD];
    assign wr_flag = flag_q[FLAG_WR];

    rra_out_dec u_dec (
        .st       (r_q.st),
        .req      (req),
        .loc_req  (loc_req),
        .cmd_sel  (cmd_sel),
        .mem_sel  (mem_sel),
        .loc_gnt  (loc_gnt),
        .xack     (xack),
        .lock_o   (lock_o),
        .mem_rd   (mem_rd),
        .abus_oe  (abus_oe),
        .adbus_oe (adbus_oe),
        .rd_src   (rd_src)
    );
endmodule

// File: rtl/rra_checker.sv
module rra_checker
    import rra_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rem_en,
    input logic       rem_rd,
    input logic       lockout,
    input logic       loc_req,
    input logic       wr_done,
    input logic       clr_rd_flag,
    input logic       loc_gnt,
    input logic       xack,
    input logic       lock_o,
    input logic       mem_rd,
    input logic       abus_oe,
    input logic       adbus_oe,
    input logic       rd_flag,
    input logic       wr_flag,
    input rra_state_e st
);
    p_ack_low_on_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && rem_en && rem_rd) |-> !xack);

    p_lockout_holds_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && lockout) |=> (st == ST_IDLE));

    p_local_pending_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && loc_req) |=> (st == ST_IDLE));

    p_no_grant_when_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> !loc_gnt);

    p_memrd_buses_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (!abus_oe && !adbus_oe && lock_o));

    p_term_waits_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TERM && rem_rd) |=> (st == ST_TERM));

    p_rd_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flag && !clr_rd_flag) |=> rd_flag);

    p_wr_flag_sets_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> wr_flag);
endmodule

bind remote_read_arbiter rra_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rem_en      (rem_en),
    .rem_rd      (rem_rd),
    .lockout     (lockout),
    .loc_req     (loc_req),
    .wr_done     (wr_done),
    .clr_rd_flag (clr_rd_flag),
    .loc_gnt     (loc_gnt),
    .xack        (xack),
    .lock_o      (lock_o),
    .mem_rd      (mem_rd),
    .abus_oe     (abus_oe),
    .adbus_oe    (adbus_oe),
    .rd_flag     (rd_flag),
    .wr_flag     (wr_flag),
    .st          (r_q.st)
);

// File: tb/tb_remote_read_arbiter.sv
module tb_remote_read_arbiter;
    localparam int DW_BITS = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rem_en = 0, rem_rd = 0, cmd_sel = 0, lockout = 0, loc_req = 0;
    logic [1:0] mem_sel = 0;
    logic [DW_BITS-1:0] dwait_cfg = 0;
    logic wr_done = 0, clr_rd_flag = 0, clr_wr_flag = 0;
    logic loc_gnt, xack, lock_o, mem_rd, abus_oe, adbus_oe, rd_flag, wr_flag;
    logic [1:0] rd_src;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    remote_read_arbiter #(.DW_BITS(DW_BITS)) dut (
        .clk(clk), .rst_n(rst_n), .rem_en(rem_en), .rem_rd(rem_rd),
        .cmd_sel(cmd_sel), .mem_sel(mem_sel), .lockout(lockout),
        .loc_req(loc_req), .dwait_cfg(dwait_cfg), .wr_done(wr_done),
        .clr_rd_flag(clr_rd_flag), .clr_wr_flag(clr_wr_flag),
        .loc_gnt(loc_gnt), .xack(xack), .lock_o(lock_o), .mem_rd(mem_rd),
        .abus_oe(abus_oe), .adbus_oe(adbus_oe), .rd_src(rd_src),
        .rd_flag(rd_flag), .wr_flag(wr_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // advance to mid-cycle after the next rising edge
    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic check_idle(input string tag, input logic lr);
        chk({tag, " lock_o"}, lock_o, 0);
        chk({tag, " mem_rd"}, mem_rd, 0);
        chk({tag, " abus_oe"}, abus_oe, 1);
        chk({tag, " adbus_oe"}, adbus_oe, 1);
        chk({tag, " rd_src"}, rd_src, 0);
        chk({tag, " loc_gnt"}, loc_gnt, lr);
    endtask

    task automatic run_read(input logic c, input logic [1:0] ms,
                            input int dw, input int hold);
        bit dm;
        int src;
        dm  = !c && !ms[1];
        src = c ? 0 : (dm ? 3 : int'(ms) - 1);
        rem_en = 1; rem_rd = 1; cmd_sel = c; mem_sel = ms;
        dwait_cfg = DW_BITS'(dw); loc_req = 0;
        settle();
        chk("R2 xack low on request", xack, 0);
        chk("R11 rd_flag clear before read", rd_flag, 0);
        tick();
        loc_req = 1;
        settle();
        chk("R4 setup lock", lock_o, 1);
        chk("R6 setup xack", xack, 1);
        chk("R6 setup abus_oe", abus_oe, 0);
        chk("R6 setup adbus_oe", adbus_oe, dm ? 0 : 1);
        chk("R5 no grant in setup", loc_gnt, 0);
        tick();
        if (dm) begin
            for (int i = 0; i <= dw; i++) begin
                chk(ms == 2'b01 ? "R9 mem_rd" : "R8 mem_rd", mem_rd, 1);
                chk("R8 adbus_oe", adbus_oe, 0);
                chk("R8 abus_oe", abus_oe, 0);
                chk("R7 rd_src data memory", rd_src, 3);
                chk("R5 no grant in memory read", loc_gnt, 0);
                tick();
            end
        end else begin
            chk("R7 rd_src", rd_src, src);
            chk("R7 mem_rd", mem_rd, 0);
            chk("R7 adbus_oe", adbus_oe, 1);
            chk("R7 lock", lock_o, 1);
            chk("R5 no grant in target", loc_gnt, 0);
            tick();
        end
        for (int k = 0; k <= hold; k++) begin
            chk("R10 term lock low", lock_o, 0);
            chk("R10 term xack", xack, 1);
            chk("R10 term mem_rd", mem_rd, 0);
            chk("R11 rd_flag set", rd_flag, 1);
            chk("R5 no grant in term", loc_gnt, 0);
            if (k == hold) rem_rd = 0;
            tick();
        end
        settle();
        check_idle("R10 back to idle", 1'b1);
        chk("R10 idle xack", xack, 1);
        loc_req = 0; clr_rd_flag = 1;
        tick();
        clr_rd_flag = 0;
        settle();
        chk("R11 rd_flag cleared", rd_flag, 0);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        #25;
        settle();
        // R1 reset state
        check_idle("R1 reset", 1'b0);
        chk("R1 reset rd_flag", rd_flag, 0);
        chk("R1 reset wr_flag", wr_flag, 0);
        chk("R1 reset xack", xack, 1);
        rst_n = 1;
        tick();
        loc_req = 1;
        settle();
        chk("R1 idle grant follows request", loc_gnt, 1);
        loc_req = 0;
        settle();
        chk("R1 idle grant drops", loc_gnt, 0);

        // R2 enable low: no request
        rem_rd = 1; rem_en = 0;
        settle();
        chk("R2 xack high with enable low", xack, 1);
        tick();
        settle();
        chk("R2 stays idle with enable low", lock_o, 0);
        rem_rd = 0;

        // R3 lockout holds idle
        lockout = 1; rem_en = 1; rem_rd = 1;
        for (int i = 0; i < 5; i++) begin
            loc_req = i[0];
            settle();
            chk("R3 lockout xack low", xack, 0);
            chk("R3 lockout lock low", lock_o, 0);
            chk("R3 lockout grant", loc_gnt, i[0]);
            tick();
        end
        settle();
        chk("R3 lockout still idle", lock_o, 0);

        // R4 pending local request blocks leaving idle
        lockout = 0; loc_req = 1;
        for (int i = 0; i < 3; i++) begin
            settle();
            chk("R4 grant while remote waits", loc_gnt, 1);
            chk("R2 xack low with local busy", xack, 0);
            tick();
            settle();
            chk("R4 held idle", lock_o, 0);
        end
        loc_req = 0;
        tick();
        settle();
        chk("R4 leaves idle when local free", lock_o, 1);
        cmd_sel = 1;
        tick(); tick();
        rem_rd = 0;
        tick();
        clr_rd_flag = 1;
        tick();
        clr_rd_flag = 0;
        rem_en = 0;

        // sweep R6 R7 R8 R9 R10 R11
        for (int c = 0; c < 2; c++)
            for (int ms = 0; ms < 4; ms++)
                for (int dw = 0; dw < 8; dw++)
                    for (int h = 0; h < 3; h++)
                        run_read(c[0], ms[1:0], dw, h);

        // R11 set and clear in the same cycle: set wins
        rem_en = 1; rem_rd = 1; cmd_sel = 1;
        tick();
        tick();
        clr_rd_flag = 1;
        tick();
        clr_rd_flag = 0;
        settle();
        chk("R11 set beats clear", rd_flag, 1);
        rem_rd = 0;
        tick();
        clr_rd_flag = 1;
        tick();
        clr_rd_flag = 0;
        settle();
        chk("R11 clear after read", rd_flag, 0);
        rem_en = 0;

        // R12 write flag
        wr_done = 1;
        tick();
        wr_done = 0;
        settle();
        chk("R12 wr_flag set", wr_flag, 1);
        clr_rd_flag = 1;
        tick();
        clr_rd_flag = 0;
        settle();
        chk("R12 wr_flag ignores rd clear", wr_flag, 1);
        tick();
        settle();
        chk("R12 wr_flag sticky", wr_flag, 1);
        clr_wr_flag = 1; wr_done = 1;
        tick();
        clr_wr_flag = 0; wr_done = 0;
        settle();
        chk("R12 set beats clear", wr_flag, 1);
        clr_wr_flag = 1;
        tick();
        clr_wr_flag = 0;
        settle();
        chk("R12 wr_flag cleared", wr_flag, 0);
        chk("R12 rd_flag untouched", rd_flag, 0);

        done = 1;
        summary();
    end
endmodule